// File: doc/BRIEF.md
# Upper-Level Page Table Entry Cache

This block is a small, private, read-only cache that a hardware page walker consults before it reads an upper-level page table entry from memory. The cache is addressed by the physical location of the entry, like a data cache. That location is the physical page number of the table page together with the index into that page. At each step of a walk, the walker presents this location. On a hit, the cache returns the physical page number of the next-lower table page one cycle later, and no memory access is needed. On a miss, the walker reads memory and then writes the result back into the cache. Entries from the three upper tree levels share a single array. If every upper step of a walk hits, only the leaf entry still needs a memory read.

The array is fully associative, 16 entries by default, and uses least-recently-used replacement. Software keeps the cache consistent with the page tables by pulsing a flush input, which empties the whole array. No hardware coherence is involved. Leaf entries are never stored, because the TLB already holds them.

Top module: `pte_loc_cache`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are low and no lookup hits until a fill has been made.
- R2: A lookup presented with `lk_valid` high in cycle T gives `rsp_valid` high in cycle T+1. In that cycle `rsp_hit` and `rsp_next` report the result, and `rsp_next` is zero on a miss.
- R3: The tag is the full `{lk_base, lk_idx}` location (40 + 9 bits). A lookup hits only if every tag bit equals a stored tag.
- R4: `fill_level` codes 1, 2 and 3 (the three upper levels) are stored side by side in the same array. A fill with code 0 (leaf) changes no entry.
- R5: A fill whose tag is already stored overwrites that entry's data in place. No second copy is made, so no other entry is displaced.
- R6: The array holds `ENTRIES` distinct tags at once. Empty slots are used before any valid entry is evicted.
- R7: When the array is full, a fill of a new tag evicts the entry least recently used. Both lookup hits and fills count as a use. When a fill and a hitting lookup share a cycle, only the fill counts.
- R8: `flush` empties every entry in one cycle. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is dropped.
- R9: A lookup in the same cycle as a fill sees the contents as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_base | input | 40 | Table page number of the looked-up entry |
| lk_idx | input | 9 | Index within the table page |
| fill_valid | input | 1 | Fill request |
| fill_level | input | 2 | Tree level of the filled entry: 0 leaf, 1..3 upper |
| fill_base | input | 40 | Table page number of the filled entry |
| fill_idx | input | 9 | Index of the filled entry |
| fill_next | input | 40 | Next-level page number to store |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_next | output | 40 | Next-level page number on hit, zero on miss |

## Verification
The bench targets tags that differ from a stored tag in a single bit, in either the page number or the index. A compare that ignored some tag bits would report false hits on these. It refills tags that are already stored and then checks that every other entry survives. A design that created duplicates would silently lose a victim. A reference model with usage timestamps follows a long pseudo-random mix of lookups, fills and flushes, which exposes victim selection that drifts from true LRU order. Directed same-cycle cases cover flush with lookup, flush with fill, fill with lookup and leaf-level fills. Wrong priorities there would show up as stale hits, resurrected entries or a lookup that sees data written in the same cycle.

// File: rtl/pec_pkg.sv
`timescale 1ns/1ps
package pec_pkg;
   typedef enum logic [1:0] {
      LVL_LEAF = 2'd0,
      LVL_DIR  = 2'd1,
      LVL_PTR  = 2'd2,
      LVL_ROOT = 2'd3
   } pec_level_e;
endpackage

// File: rtl/pec_cam.sv
`timescale 1ns/1ps
module pec_cam #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 49,
   parameter int DATA_W  = 40,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IW-1:0]      wr_slot,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] wr_match,
   output logic [ENTRIES-1:0] valid_q,
   output logic [DATA_W-1:0]  rd_data
);
   logic [TAG_W-1:0]  tag_q  [ENTRIES];
   logic [DATA_W-1:0] data_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag);
      assign wr_match[g] = valid_q[g] && (tag_q[g] == wr_tag);

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            valid_q[g] <= 1'b0;
         end else if (wr_en && wr_slot == IW'(g)) begin
            valid_q[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && !flush && wr_slot == IW'(g)) begin
            tag_q[g]  <= wr_tag;
            data_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) rd_data = rd_data | data_q[i];
      end
   end

   p_unique_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match) && $onehot0(wr_match));
   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
endmodule

// File: rtl/pec_lru.sv
`timescale 1ns/1ps
module pec_lru #(
   parameter int ENTRIES = 16,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_slot,
   output logic [IW-1:0] oldest_slot
);
   logic [IW-1:0]      age_q [ENTRIES];
   logic [ENTRIES-1:0] is_oldest;
   logic [IW-1:0]      touched_age;

   assign touched_age = age_q[touch_slot];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      assign is_oldest[g] = (age_q[g] == IW'(ENTRIES - 1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q[g] <= IW'(g);
         end else if (touch_en) begin
            if (touch_slot == IW'(g))        age_q[g] <= '0;
            else if (age_q[g] < touched_age) age_q[g] <= age_q[g] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_slot = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (is_oldest[i]) oldest_slot = IW'(i);
      end
   end

   p_single_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(is_oldest));
   p_touch_youngest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (oldest_slot != $past(touch_slot)));
endmodule

// File: rtl/pte_loc_cache.sv
`timescale 1ns/1ps
module pte_loc_cache #(
   parameter int PPN_W   = 40,
   parameter int IDX_W   = 9,
   parameter int ENTRIES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic [PPN_W-1:0] lk_base,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic             fill_valid,
   input  logic [1:0]       fill_level,
   input  logic [PPN_W-1:0] fill_base,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [PPN_W-1:0] fill_next,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [PPN_W-1:0] rsp_next
);
   import pec_pkg::*;

   localparam int TAG_W = PPN_W + IDX_W;
   localparam int IW    = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_chk_depth
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (PPN_W < 1 || IDX_W < 1) begin : g_chk_width
      $error("PPN_W and IDX_W must be positive");
   end

   logic [TAG_W-1:0]   lk_tag, wr_tag;
   logic [ENTRIES-1:0] lk_match, wr_match, valid_q;
   logic [PPN_W-1:0]   rd_data;
   logic [IW-1:0]      oldest_slot, lk_slot, dup_slot, free_slot, wr_slot, touch_slot;
   logic               fill_ok, lk_hit_now, has_free, touch_en;
   pec_level_e         lvl;

   assign lk_tag = {lk_base, lk_idx};
   assign wr_tag = {fill_base, fill_idx};
   assign lvl    = pec_level_e'(fill_level);

   assign fill_ok    = fill_valid && (lvl != LVL_LEAF) && !flush;
   assign lk_hit_now = lk_valid && (|lk_match) && !flush;
   assign has_free   = !(&valid_q);

   always_comb begin
      lk_slot   = '0;
      dup_slot  = '0;
      free_slot = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_match[i]) lk_slot   = IW'(i);
         if (wr_match[i]) dup_slot  = IW'(i);
         if (!valid_q[i]) free_slot = IW'(i);
      end
   end

   always_comb begin
      if (|wr_match)     wr_slot = dup_slot;
      else if (has_free) wr_slot = free_slot;
      else               wr_slot = oldest_slot;
   end

   assign touch_en   = fill_ok || lk_hit_now;
   assign touch_slot = fill_ok ? wr_slot : lk_slot;

   pec_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(PPN_W)) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (fill_ok),
      .wr_slot  (wr_slot),
      .wr_tag   (wr_tag),
      .wr_data  (fill_next),
      .lk_tag   (lk_tag),
      .lk_match (lk_match),
      .wr_match (wr_match),
      .valid_q  (valid_q),
      .rd_data  (rd_data)
   );

   pec_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .touch_en    (touch_en),
      .touch_slot  (touch_slot),
      .oldest_slot (oldest_slot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_next  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_hit_now;
         rsp_next  <= lk_hit_now ? rd_data : '0;
      end
   end

   p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_hit && rsp_next == '0));
   p_flush_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lk_valid) |=> (rsp_valid && !rsp_hit));
   p_leaf_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_level == 2'd0 && !flush) |=> $stable(valid_q));
endmodule

// File: tb/tb_pte_loc_cache.sv
`timescale 1ns/1ps
module tb_pte_loc_cache;
   localparam int PW = 40;
   localparam int XW = 9;
   localparam int N  = 16;
   localparam int NK = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          lk_valid = 1'b0;
   logic [PW-1:0] lk_base = '0;
   logic [XW-1:0] lk_idx = '0;
   logic          fill_valid = 1'b0;
   logic [1:0]    fill_level = 2'd1;
   logic [PW-1:0] fill_base = '0;
   logic [XW-1:0] fill_idx = '0;
   logic [PW-1:0] fill_next = '0;
   logic          rsp_valid, rsp_hit;
   logic [PW-1:0] rsp_next;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // model: which key sits in cache, its data, last-use time
   bit            m_val   [NK];
   logic [PW-1:0] m_data  [NK];
   longint        m_stamp [NK];
   longint        now = 0;

   always #5 clk = ~clk;

   pte_loc_cache dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_base(lk_base), .lk_idx(lk_idx),
      .fill_valid(fill_valid), .fill_level(fill_level), .fill_base(fill_base),
      .fill_idx(fill_idx), .fill_next(fill_next),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next(rsp_next)
   );

   function automatic logic [PW-1:0] base_of(int k);
      return 40'h00A0_0000_00 + PW'(k) * 40'h0000_1_0001;
   endfunction
   function automatic logic [XW-1:0] idx_of(int k);
      return XW'((k * 53 + 7) % 512);
   endfunction
   function automatic logic [PW-1:0] data_of(int k, int ver);
      return 40'h50_0000_0000 + PW'(k) * 40'd4096 + PW'(ver);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int m_count();
      int c = 0;
      for (int i = 0; i < NK; i++) if (m_val[i]) c++;
      return c;
   endfunction

   task automatic m_fill(input int k, input logic [PW-1:0] d);
      now++;
      if (!m_val[k] && m_count() == N) begin
         int v = -1;
         for (int i = 0; i < NK; i++)
            if (m_val[i] && (v < 0 || m_stamp[i] < m_stamp[v])) v = i;
         m_val[v] = 1'b0;
      end
      m_val[k] = 1'b1; m_data[k] = d; m_stamp[k] = now;
   endtask

   task automatic m_flush();
      for (int i = 0; i < NK; i++) m_val[i] = 1'b0;
   endtask

   // one cycle: drive at negedge, result visible at following negedge
   task automatic step(input bit lv, input logic [PW-1:0] lb, input logic [XW-1:0] li,
                       input bit fv, input int fk, input logic [1:0] flv,
                       input logic [PW-1:0] fd, input bit fl);
      lk_valid = lv; lk_base = lb; lk_idx = li;
      fill_valid = fv; fill_level = flv; fill_base = base_of(fk);
      fill_idx = idx_of(fk); fill_next = fd; flush = fl;
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic look_raw(input logic [PW-1:0] lb, input logic [XW-1:0] li,
                           input bit exp_hit, input logic [PW-1:0] exp_d, input string req);
      step(1'b1, lb, li, 1'b0, 0, 2'd1, '0, 1'b0);
      check(rsp_valid === 1'b1, req, rsp_valid, 1);
      check(rsp_hit === exp_hit, req, rsp_hit, exp_hit);
      check(rsp_next === (exp_hit ? exp_d : '0), req, rsp_next, exp_hit ? exp_d : '0);
   endtask

   task automatic look_key(input int k, input string req);
      bit h = m_val[k];
      logic [PW-1:0] d = m_data[k];
      if (h) begin now++; m_stamp[k] = now; end
      look_raw(base_of(k), idx_of(k), h, d, req);
   endtask

   task automatic fill_key(input int k, input logic [1:0] lvl, input logic [PW-1:0] d);
      step(1'b0, '0, '0, 1'b1, k, lvl, d, 1'b0);
      if (lvl != 2'd0) m_fill(k, d);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual=hang expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < NK; i++) begin m_val[i] = 0; m_stamp[i] = 0; m_data[i] = '0; end
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1 reset outputs", {rsp_valid, rsp_hit}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      look_key(0, "R1 empty after reset");

      // R6 / R4: fill sixteen keys across the three upper levels
      for (int k = 0; k < N; k++) fill_key(k, 2'(1 + k % 3), data_of(k, 0));
      for (int k = 0; k < N; k++) look_key(k, "R6 R4 R2 all sixteen retained");

      // R3: single-bit differences never hit
      for (int k = 0; k < 4; k++) begin
         for (int b = 0; b < PW; b += 7)
            look_raw(base_of(k) ^ (PW'(1) << b), idx_of(k), 1'b0, '0, "R3 base bit differs");
         for (int b = 0; b < XW; b++)
            look_raw(base_of(k), idx_of(k) ^ (XW'(1) << b), 1'b0, '0, "R3 index bit differs");
      end

      // R4: leaf fill stores nothing and evicts nothing
      fill_key(20, 2'd0, data_of(20, 9));
      look_key(20, "R4 leaf fill ignored");
      for (int k = 0; k < N; k++) look_key(k, "R4 leaf fill evicted nothing");

      // R5: refill existing tag updates in place
      fill_key(3, 2'd2, data_of(3, 5));
      look_key(3, "R5 refill new data");
      for (int k = 0; k < N; k++) look_key(k, "R5 no duplicate displaced");

      // R7 directed: after flush, fill 0..15, touch 0, add 16 -> 1 evicted
      step(1'b0, '0, '0, 1'b0, 0, 2'd1, '0, 1'b1); m_flush();
      for (int k = 0; k < N; k++) fill_key(k, 2'd3, data_of(k, 1));
      look_key(0, "R7 touch");
      fill_key(16, 2'd1, data_of(16, 1));
      look_key(1, "R7 LRU victim evicted");
      look_key(0, "R7 recently used kept");
      look_key(16, "R7 new entry present");

      // R7 pseudo-random mix against timestamp model
      for (int n = 0; n < 3000; n++) begin
         int k, op;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         k  = int'(lfsr[4:0]) % NK;
         op = int'(lfsr[13:8]);
         if (op == 0) begin
            step(1'b0, '0, '0, 1'b0, 0, 2'd1, '0, 1'b1); m_flush();
         end else if (op < 20) begin
            fill_key(k, 2'(1 + op % 3), data_of(k, n));
         end else begin
            look_key(k, "R7 random LRU sequence");
         end
      end

      // R8: flush with lookup misses, flush with fill dropped
      step(1'b0, '0, '0, 1'b0, 0, 2'd1, '0, 1'b1); m_flush();
      fill_key(5, 2'd1, data_of(5, 2));
      step(1'b1, base_of(5), idx_of(5), 1'b0, 0, 2'd1, '0, 1'b1); m_flush();
      check(rsp_valid === 1'b1 && rsp_hit === 1'b0, "R8 lookup during flush", rsp_hit, 0);
      look_key(5, "R8 flushed entry gone");
      step(1'b0, '0, '0, 1'b1, 6, 2'd2, data_of(6, 2), 1'b1);
      look_key(6, "R8 fill during flush dropped");

      // R9: lookup sees pre-fill contents
      step(1'b1, base_of(7), idx_of(7), 1'b1, 7, 2'd1, data_of(7, 3), 1'b0);
      check(rsp_hit === 1'b0, "R9 same-cycle fill not visible", rsp_hit, 0);
      m_fill(7, data_of(7, 3));
      look_key(7, "R9 visible next cycle");
      step(1'b1, base_of(7), idx_of(7), 1'b1, 7, 2'd1, data_of(7, 4), 1'b0);
      check(rsp_hit === 1'b1 && rsp_next === data_of(7, 3), "R9 old data returned", rsp_next, data_of(7, 3));
      m_fill(7, data_of(7, 4));
      look_key(7, "R9 new data after");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule